// File: doc/BRIEF.md
# Sub-dword operand select unit

This block formats the operands and the result of a vector ALU, one 32-bit word per lane. Both source paths pick a byte, a halfword or the whole word from their operand, move the chosen field down to bit 0 and fill the bits above it with zeros or with copies of the field's top bit. The destination path merges a narrow ALU result into the previous contents of the destination word. Its two-bit fill mode decides what the bytes outside the selected field become.

The same select, extend and fill controls apply to every lane, and the lane count is a parameter. All outputs are registered, so results appear one clock after the inputs are presented. An out-of-range select code raises an error flag. In that case the affected path passes its word through unchanged.

Top module: `sdw_lane_array`

## Requirements
- R1: Select codes 0 to 3 pick byte 0 to 3 of each source word (bits 7:0, 15:8, 23:16, 31:24). Codes 4 and 5 pick the low halfword (bits 15:0) and the high halfword (bits 31:16). The picked field appears at bit 0, and with the extend flag at 0 all bits above it are zero.
- R2: With the source extend flag at 1, the bits above a picked byte or halfword copy the field's top bit.
- R3: Source select code 6 returns the source word unchanged, whatever the extend flag is.
- R4: For destination select codes 0 to 3, the selected byte position takes the result's byte from that same position. In fill mode 0 (zero) every other byte is zero.
- R5: In fill mode 1 (sign), the bytes above the selected byte are 0xFF when bit 7 of the selected result byte is 1, and zero otherwise. Bytes below the selected byte are zero.
- R6: In fill mode 2 (keep), every byte outside the selected one takes the previous destination byte.
- R7: Destination codes 4 and 5 apply the rules of R4 to R6 per 16-bit half. Code 4 selects bits 15:0 and code 5 selects bits 31:16. Only the high half can be sign-filled, from bit 15 of the result.
- R8: Destination code 6 writes the whole result word, whatever the fill mode is. Fill mode 3 behaves as fill mode 0.
- R9: Select code 7 on any path sets `sel_err_o` to 1 for that cycle's result. The affected source path then passes its operand unchanged, and the destination path passes the result unchanged.
- R10: Every output is registered, with a latency of one clock. A synchronous active-low reset clears all outputs, including `sel_err_o`, to zero.
- R11: Lanes are independent. Lane k uses bits [32k+31:32k] of each bus and drives the same bit positions of each output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_a_i | input | 32*LANES | First source operand, one word per lane |
| src_a_sel | input | 3 | Field select for the first source |
| src_a_sext | input | 1 | Sign-extend flag for the first source |
| src_b_i | input | 32*LANES | Second source operand, one word per lane |
| src_b_sel | input | 3 | Field select for the second source |
| src_b_sext | input | 1 | Sign-extend flag for the second source |
| dst_res_i | input | 32*LANES | ALU result, one word per lane |
| dst_old_i | input | 32*LANES | Previous destination contents |
| dst_sel | input | 3 | Field select for the destination |
| dst_fill | input | 2 | Fill mode for unselected destination bits |
| src_a_o | output | 32*LANES | Formatted first source |
| src_b_o | output | 32*LANES | Formatted second source |
| dst_o | output | 32*LANES | Merged destination word |
| sel_err_o | output | 1 | An illegal select code was seen |

## Verification
The assertions assume that the select and fill inputs are known (not X) in every cycle after reset. They also assume that the value sampled one clock earlier is the one the registered outputs reflect, which is why every property first requires that reset was already released in the previous cycle. The stimulus keeps to this. It changes inputs only on the falling edge, holds them stable across each rising edge, and drives defined values on every control input from the first cycle, including during reset.

// File: rtl/sdw_pkg.sv
// Shared constants for the sub-dword operand select unit.
// Assumes 32-bit lane words made of four bytes or two halfwords.
package sdw_pkg;
    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int HALF_W  = 16;
    localparam int NBYTES  = WORD_W / BYTE_W;
    localparam int NHALVES = WORD_W / HALF_W;

    localparam logic [2:0] SEL_BYTE3 = 3'd3;
    localparam logic [2:0] SEL_HALF1 = 3'd5;
    localparam logic [2:0] SEL_WORD  = 3'd6;
    localparam logic [2:0] SEL_BAD   = 3'd7;

    localparam logic [1:0] FILL_ZERO = 2'd0;
    localparam logic [1:0] FILL_SIGN = 2'd1;
    localparam logic [1:0] FILL_KEEP = 2'd2;
endpackage

// File: rtl/sdw_src_fmt.sv
// Source-side formatter for one lane: extracts a byte, halfword or word
// and zero- or sign-extends it to 32 bits.
// Assumes select codes 6 and 7 both leave the operand untouched.
module sdw_src_fmt
    import sdw_pkg::*;
(
    input  logic [WORD_W-1:0] opnd_i,
    input  logic [2:0]        sel_i,
    input  logic              sext_i,
    output logic [WORD_W-1:0] fmt_o
);
    logic [BYTE_W-1:0] fld8;
    logic [HALF_W-1:0] fld16;

    // Candidate fields picked by the low select bits
    assign fld8  = opnd_i[{sel_i[1:0], 3'b000} +: BYTE_W];
    assign fld16 = opnd_i[{sel_i[0], 4'b0000} +: HALF_W];

    // Choose the field width and extend it to a full word
    always_comb begin
        fmt_o = opnd_i;
        if (sel_i <= SEL_BYTE3) begin
            fmt_o = {{(WORD_W-BYTE_W){sext_i & fld8[BYTE_W-1]}}, fld8};
        end else if (sel_i <= SEL_HALF1) begin
            fmt_o = {{(WORD_W-HALF_W){sext_i & fld16[HALF_W-1]}}, fld16};
        end
    end
endmodule

// File: rtl/sdw_dst_merge.sv
// Destination-side merger for one lane: keeps the selected field of the
// result in place and fills the rest by zero, sign or old-value policy.
// Assumes fill code 3 behaves as zero fill; select 6 and 7 pass the result.
module sdw_dst_merge
    import sdw_pkg::*;
(
    input  logic [WORD_W-1:0] res_i,
    input  logic [WORD_W-1:0] old_i,
    input  logic [2:0]        sel_i,
    input  logic [1:0]        fill_i,
    output logic [WORD_W-1:0] merged_o
);
    logic sgn;

    // Build each byte or half of the merged word from result, old or fill
    always_comb begin
        merged_o = res_i;
        sgn      = 1'b0;
        if (sel_i <= SEL_BYTE3) begin
            sgn = (fill_i == FILL_SIGN) && res_i[{sel_i[1:0], 3'b111}];
            for (int b = 0; b < NBYTES; b++) begin
                if (b == int'(sel_i[1:0]))
                    merged_o[b*BYTE_W +: BYTE_W] = res_i[b*BYTE_W +: BYTE_W];
                else if (fill_i == FILL_KEEP)
                    merged_o[b*BYTE_W +: BYTE_W] = old_i[b*BYTE_W +: BYTE_W];
                else if ((b > int'(sel_i[1:0])) && sgn)
                    merged_o[b*BYTE_W +: BYTE_W] = '1;
                else
                    merged_o[b*BYTE_W +: BYTE_W] = '0;
            end
        end else if (sel_i <= SEL_HALF1) begin
            sgn = (fill_i == FILL_SIGN) && res_i[{sel_i[0], 4'b1111}];
            for (int h = 0; h < NHALVES; h++) begin
                if (h == int'(sel_i[0]))
                    merged_o[h*HALF_W +: HALF_W] = res_i[h*HALF_W +: HALF_W];
                else if (fill_i == FILL_KEEP)
                    merged_o[h*HALF_W +: HALF_W] = old_i[h*HALF_W +: HALF_W];
                else if ((h > int'(sel_i[0])) && sgn)
                    merged_o[h*HALF_W +: HALF_W] = '1;
                else
                    merged_o[h*HALF_W +: HALF_W] = '0;
            end
        end
    end
endmodule

// File: rtl/sdw_lane_array.sv
// Top of the sub-dword operand select unit: replicates two source
// formatters and one destination merger per lane and registers all results.
// Assumes controls are shared by all lanes; reset is synchronous, active low.
module sdw_lane_array
    import sdw_pkg::*;
#(
    parameter int LANES = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANES*WORD_W-1:0]   src_a_i,
    input  logic [2:0]                src_a_sel,
    input  logic                      src_a_sext,
    input  logic [LANES*WORD_W-1:0]   src_b_i,
    input  logic [2:0]                src_b_sel,
    input  logic                      src_b_sext,
    input  logic [LANES*WORD_W-1:0]   dst_res_i,
    input  logic [LANES*WORD_W-1:0]   dst_old_i,
    input  logic [2:0]                dst_sel,
    input  logic [1:0]                dst_fill,
    output logic [LANES*WORD_W-1:0]   src_a_o,
    output logic [LANES*WORD_W-1:0]   src_b_o,
    output logic [LANES*WORD_W-1:0]   dst_o,
    output logic                      sel_err_o
);
    localparam int BUS_W = LANES * WORD_W;

    logic [BUS_W-1:0] a_nxt, b_nxt, d_nxt;
    logic             err_nxt;

    // Any path carrying the reserved select code flags an error
    assign err_nxt = (src_a_sel == SEL_BAD) | (src_b_sel == SEL_BAD) |
                     (dst_sel == SEL_BAD);

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        sdw_src_fmt u_src_a (
            .opnd_i (src_a_i[ln*WORD_W +: WORD_W]),
            .sel_i  (src_a_sel),
            .sext_i (src_a_sext),
            .fmt_o  (a_nxt[ln*WORD_W +: WORD_W])
        );
        sdw_src_fmt u_src_b (
            .opnd_i (src_b_i[ln*WORD_W +: WORD_W]),
            .sel_i  (src_b_sel),
            .sext_i (src_b_sext),
            .fmt_o  (b_nxt[ln*WORD_W +: WORD_W])
        );
        sdw_dst_merge u_dst (
            .res_i    (dst_res_i[ln*WORD_W +: WORD_W]),
            .old_i    (dst_old_i[ln*WORD_W +: WORD_W]),
            .sel_i    (dst_sel),
            .fill_i   (dst_fill),
            .merged_o (d_nxt[ln*WORD_W +: WORD_W])
        );
    end

    // Output stage: one register per result bit, cleared on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_a_o   <= '0;
            src_b_o   <= '0;
            dst_o     <= '0;
            sel_err_o <= 1'b0;
        end else begin
            src_a_o   <= a_nxt;
            src_b_o   <= b_nxt;
            dst_o     <= d_nxt;
            sel_err_o <= err_nxt;
        end
    end
endmodule

// File: rtl/sdw_lane_array_chk.sv
// Property checker for sdw_lane_array, attached through bind.
// Assumes inputs are known after reset; every property waits one cycle past reset.
module sdw_lane_array_chk
    import sdw_pkg::*;
#(
    parameter int LANES = 64
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [LANES*WORD_W-1:0] src_a_i,
    input logic [2:0]              src_a_sel,
    input logic [LANES*WORD_W-1:0] src_b_i,
    input logic [2:0]              src_b_sel,
    input logic                    src_b_sext,
    input logic [LANES*WORD_W-1:0] dst_res_i,
    input logic [LANES*WORD_W-1:0] dst_old_i,
    input logic [2:0]              dst_sel,
    input logic [1:0]              dst_fill,
    input logic [LANES*WORD_W-1:0] src_a_o,
    input logic [LANES*WORD_W-1:0] src_b_o,
    input logic [LANES*WORD_W-1:0] dst_o,
    input logic                    sel_err_o
);
    // R9
    err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> sel_err_o == (($past(src_a_sel) == 3'd7) ||
                                       ($past(src_b_sel) == 3'd7) ||
                                       ($past(dst_sel) == 3'd7)));

    // R3
    src_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(src_a_sel) == 3'd6) |-> src_a_o == $past(src_a_i));

    // R8
    dst_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dst_sel) == 3'd6) |-> dst_o == $past(dst_res_i));

    // R1
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(src_b_sel) <= 3'd3 && !$past(src_b_sext))
        |-> src_b_o[WORD_W-1:BYTE_W] == '0);

    for (genvar b = 0; b < NBYTES; b++) begin : g_keep
        // R6
        keep_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(dst_sel) <= 3'd3 && $past(dst_fill) == 2'd2 &&
             $past(dst_sel) != 3'(b))
            |-> dst_o[b*BYTE_W +: BYTE_W] == $past(dst_old_i[b*BYTE_W +: BYTE_W]));
    end
endmodule

bind sdw_lane_array sdw_lane_array_chk #(.LANES(LANES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_a_i    (src_a_i),
    .src_a_sel  (src_a_sel),
    .src_b_i    (src_b_i),
    .src_b_sel  (src_b_sel),
    .src_b_sext (src_b_sext),
    .dst_res_i  (dst_res_i),
    .dst_old_i  (dst_old_i),
    .dst_sel    (dst_sel),
    .dst_fill   (dst_fill),
    .src_a_o    (src_a_o),
    .src_b_o    (src_b_o),
    .dst_o      (dst_o),
    .sel_err_o  (sel_err_o)
);

// File: tb/sdw_lane_array_tb.sv
module sdw_lane_array_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 64;
    localparam int BUS_W      = LANES * 32;
    localparam int WATCHDOG   = 5000;

    localparam logic [31:0] OPA = 32'h8A7B_C6D5;
    localparam logic [31:0] RES = 32'h1E9F_80C4;
    localparam logic [31:0] OLD = 32'h5566_7788;

    typedef struct packed {
        logic [2:0]  sa;
        logic        xa;
        logic [2:0]  sd;
        logic [1:0]  fd;
        logic [31:0] ea;
        logic [31:0] eb;
        logic [31:0] ed;
        logic        er;
    } vec_t;

    // Source B gets the inverse of OPA with the same select and extend flag
    localparam vec_t VECS [12] = '{
        '{3'd0, 1'b0, 3'd0, 2'd0, 32'h0000_00D5, 32'h0000_002A, 32'h0000_00C4, 1'b0},
        '{3'd0, 1'b1, 3'd0, 2'd1, 32'hFFFF_FFD5, 32'h0000_002A, 32'hFFFF_FFC4, 1'b0},
        '{3'd1, 1'b1, 3'd1, 2'd1, 32'hFFFF_FFC6, 32'h0000_0039, 32'hFFFF_8000, 1'b0},
        '{3'd2, 1'b1, 3'd2, 2'd1, 32'h0000_007B, 32'hFFFF_FF84, 32'hFF9F_0000, 1'b0},
        '{3'd3, 1'b1, 3'd3, 2'd1, 32'hFFFF_FF8A, 32'h0000_0075, 32'h1E00_0000, 1'b0},
        '{3'd4, 1'b0, 3'd1, 2'd2, 32'h0000_C6D5, 32'h0000_392A, 32'h5566_8088, 1'b0},
        '{3'd4, 1'b1, 3'd4, 2'd1, 32'hFFFF_C6D5, 32'h0000_392A, 32'hFFFF_80C4, 1'b0},
        '{3'd5, 1'b0, 3'd5, 2'd1, 32'h0000_8A7B, 32'h0000_7584, 32'h1E9F_0000, 1'b0},
        '{3'd5, 1'b1, 3'd5, 2'd2, 32'hFFFF_8A7B, 32'h0000_7584, 32'h1E9F_7788, 1'b0},
        '{3'd6, 1'b1, 3'd6, 2'd1, 32'h8A7B_C6D5, 32'h7584_392A, 32'h1E9F_80C4, 1'b0},
        '{3'd6, 1'b0, 3'd4, 2'd3, 32'h8A7B_C6D5, 32'h7584_392A, 32'h0000_80C4, 1'b0},
        '{3'd7, 1'b0, 3'd7, 2'd0, 32'h8A7B_C6D5, 32'h7584_392A, 32'h1E9F_80C4, 1'b1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [BUS_W-1:0] src_a_i = '0, src_b_i = '0, dst_res_i = '0, dst_old_i = '0;
    logic [2:0]       src_a_sel = '0, src_b_sel = '0, dst_sel = '0;
    logic             src_a_sext = 1'b0, src_b_sext = 1'b0;
    logic [1:0]       dst_fill = '0;
    logic [BUS_W-1:0] src_a_o, src_b_o, dst_o;
    logic             sel_err_o;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdw_lane_array #(.LANES(LANES)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .src_a_i(src_a_i), .src_a_sel(src_a_sel), .src_a_sext(src_a_sext),
        .src_b_i(src_b_i), .src_b_sel(src_b_sel), .src_b_sext(src_b_sext),
        .dst_res_i(dst_res_i), .dst_old_i(dst_old_i),
        .dst_sel(dst_sel), .dst_fill(dst_fill),
        .src_a_o(src_a_o), .src_b_o(src_b_o), .dst_o(dst_o),
        .sel_err_o(sel_err_o)
    );

    task automatic chk_bus(input string tag, input logic [BUS_W-1:0] act,
                           input logic [BUS_W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: lane0 act=%h exp=%h, last lane act=%h exp=%h", tag,
                     act[31:0], exp[31:0], act[BUS_W-1 -: 32], exp[BUS_W-1 -: 32]);
        end
    endtask

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%b exp=%b", tag, act, exp);
        end
    endtask

    // Drive on the falling edge, let one rising edge register, sample after it
    task automatic apply(input logic [2:0] sa, input logic xa, input logic [2:0] sd,
                         input logic [1:0] fd, input logic [BUS_W-1:0] a,
                         input logic [BUS_W-1:0] res, input logic [BUS_W-1:0] old);
        @(negedge clk);
        src_a_i = a;   src_a_sel = sa; src_a_sext = xa;
        src_b_i = ~a;  src_b_sel = sa; src_b_sext = xa;
        dst_res_i = res; dst_old_i = old; dst_sel = sd; dst_fill = fd;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [BUS_W-1:0] alt_a, alt_exp;
        // R10: outputs cleared while reset is held, even with live inputs
        rst_n = 1'b0;
        apply(3'd6, 1'b0, 3'd7, 2'd0, {LANES{OPA}}, {LANES{RES}}, {LANES{OLD}});
        chk_bus("R10 reset src_a", src_a_o, '0);
        chk_bus("R10 reset dst", dst_o, '0);
        chk_bit("R10 reset err", sel_err_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R6 R7 R8 R9 table walk
        for (int i = 0; i < 12; i++) begin
            apply(VECS[i].sa, VECS[i].xa, VECS[i].sd, VECS[i].fd,
                  {LANES{OPA}}, {LANES{RES}}, {LANES{OLD}});
            chk_bus($sformatf("R1/R2/R3 row %0d src_a", i), src_a_o, {LANES{VECS[i].ea}});
            chk_bus($sformatf("R1/R2/R3 row %0d src_b", i), src_b_o, {LANES{VECS[i].eb}});
            chk_bus($sformatf("R4-R8 row %0d dst", i), dst_o, {LANES{VECS[i].ed}});
            chk_bit($sformatf("R9 row %0d err", i), sel_err_o, VECS[i].er);
        end

        // R9: only the destination select is illegal
        apply(3'd0, 1'b0, 3'd7, 2'd2, {LANES{OPA}}, {LANES{RES}}, {LANES{OLD}});
        chk_bit("R9 dst-only err", sel_err_o, 1'b1);
        chk_bus("R9 dst pass", dst_o, {LANES{RES}});
        chk_bus("R1 src legal beside error", src_a_o, {LANES{32'h0000_00D5}});

        // R8: whole word under keep mode
        apply(3'd0, 1'b0, 3'd6, 2'd2, {LANES{OPA}}, {LANES{RES}}, {LANES{OLD}});
        chk_bus("R8 whole under keep", dst_o, {LANES{RES}});
        chk_bit("R9 err clears", sel_err_o, 1'b0);

        // R8: fill code 3 pads with zero on a byte select
        apply(3'd0, 1'b0, 3'd2, 2'd3, {LANES{OPA}}, {LANES{RES}}, {LANES{OLD}});
        chk_bus("R8 fill3 byte", dst_o, {LANES{32'h009F_0000}});

        // R11: alternating lane contents stay in their own lanes
        for (int k = 0; k < LANES; k++) begin
            alt_a[k*32 +: 32]   = (k % 2 == 0) ? OPA : ~OPA;
            alt_exp[k*32 +: 32] = (k % 2 == 0) ? 32'hFFFF_FF8A : 32'h0000_0075;
        end
        apply(3'd3, 1'b1, 3'd6, 2'd0, alt_a, alt_a, {LANES{OLD}});
        chk_bus("R11 lane independence src_a", src_a_o, alt_exp);
        chk_bus("R11 lane independence dst", dst_o, alt_a);

        // R10: reset in mid-run clears registered results
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk_bus("R10 mid-run reset dst", dst_o, '0);
        chk_bus("R10 mid-run reset src_b", src_b_o, '0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule